// File: doc/BRIEF.md
# Carrier Sense Hold-Off Timer

This block derives a carrier-sense level from activity on a serial receive line. Any change of level on the receive data marks the line as busy. The busy indication then stays up until a programmed quiet period passes with no further change. Downstream receive logic uses the level to tell a live line from an idle one. A one-cycle change pulse on the same clock can serve directly as an interrupt request.

The quiet period is selected by a 2-bit hold code. It is counted in strobes of a single timing input, `tick_i`. When `ovs_mode_i` is low, the receiver runs at one sample per bit and each strobe is one bit time. When it is high, the receiver oversamples by `OVS_RATIO`, so each strobe is a fraction of a bit and the half-bit holds become whole numbers of strobes. Code 00 disables the timeout altogether. The receive input is asynchronous and is resynchronised inside the block.

Top module: `cs_holdoff`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `cs_o` is 1 and `cs_chg_o` is 0 when `hold_code_i` is 00.
- R2: Hold code 00 means an infinite hold: `cs_o` is 1 on every cycle that follows a cycle with code 00, whatever the receive line does.
- R3: A level change on `rxd_i` raises `cs_o` exactly SYNC_STAGES+2 clock cycles after the change is presented (4 cycles at the default of 2 stages).
- R4: Hold code 01 keeps carrier sense for 14 strobes in one-sample mode and for 13*OVS_RATIO/2 strobes in oversampled mode (6.5 bit times, which is 104 strobes at 16x).
- R5: Hold code 10 keeps carrier sense for 4 strobes in one-sample mode and for 3*OVS_RATIO/2 strobes in oversampled mode (1.5 bit times).
- R6: Hold code 11 keeps carrier sense for 3 strobes in one-sample mode and for OVS_RATIO strobes in oversampled mode (1 bit time).
- R7: Each level change restarts the full hold. Carrier sense drops only after the programmed number of strobes has been counted since the most recent change.
- R8: `cs_chg_o` is high for exactly one cycle, in the same cycle that `cs_o` takes a new value, for both a rise and a fall.
- R9: The hold length is taken from the code and mode present when a change is detected. Altering the code or mode during a hold does not shorten or lengthen that hold; the new length applies from the next change.
- R10: Time passes only on `tick_i` strobes. With no strobes, an active carrier sense stays up indefinitely.
- R11: A strobe in the same cycle as a detected change does not count toward the new hold; the change reloads the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial receive data |
| tick_i | input | 1 | Timing strobe: one bit time, or one oversample period when oversampled |
| ovs_mode_i | input | 1 | 0 = one sample per bit, 1 = oversampled by OVS_RATIO |
| hold_code_i | input | 2 | Hold code: 00 infinite, 01 longest, 10 medium, 11 shortest |
| cs_o | output | 1 | Carrier-sense level |
| cs_chg_o | output | 1 | One-cycle pulse on every change of `cs_o` |

## Verification
A change on `rxd_i` reaches `cs_o` SYNC_STAGES+2 cycles later. With a strobe on every cycle, the fall follows SYNC_STAGES+2+N cycles after the last change, where N is the strobe count for the code. `cs_chg_o` is due in the same cycle as each change of `cs_o`. The bench drives inputs and samples outputs on the falling clock edge, so each rising edge sees settled values. A behavioural model with a delay-line queue and an integer down-count predicts both outputs for every cycle. Directed windows count falling edges from the stimulus to the observed rise and fall and compare them with these latencies.

// File: rtl/csh_pkg.sv
// Shared definitions for the carrier sense hold-off timer.
// Assumes the oversample ratio is even and at least 2, so that the
// half-bit holds become whole numbers of strobes.
package csh_pkg;

    typedef enum logic [1:0] {
        HOLD_FOREVER = 2'b00,
        HOLD_LONG    = 2'b01,
        HOLD_MEDIUM  = 2'b10,
        HOLD_SHORT   = 2'b11
    } hold_code_e;

    // Strobe count for a code in a given receiver timing mode.
    function automatic int unsigned hold_ticks(hold_code_e code, logic ovs, int unsigned ratio);
        int unsigned half;
        half = ratio / 2;
        case (code)
            HOLD_LONG:   return ovs ? 13 * half : 14;
            HOLD_MEDIUM: return ovs ? 3 * half  : 4;
            HOLD_SHORT:  return ovs ? 2 * half  : 3;
            default:     return 1;
        endcase
    endfunction

    // Largest strobe count any code can ask for.
    function automatic int unsigned max_ticks(int unsigned ratio);
        int unsigned over;
        over = 13 * (ratio / 2);
        return (over > 14) ? over : 14;
    endfunction

endpackage

// File: rtl/csh_rx_sync.sv
// Receive line synchroniser and change detector.
// Brings the asynchronous receive data into the clock domain through
// STAGES flops. It flags one cycle for every level change seen at the
// synchronised output. All flops reset to IDLE_LEVEL, so a line that
// sits at the idle level through reset produces no false change.
module csh_rx_sync #(
    parameter int   STAGES     = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    output logic change_o
);

    logic rx_sync;
    logic rx_last;

    generate
        if (STAGES <= 1) begin : g_single
            // Single capture flop when a shallow synchroniser is enough.
            always_ff @(posedge clk) begin
                if (!rst_n) rx_sync <= IDLE_LEVEL;
                else        rx_sync <= rxd_i;
            end
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            // Shift the raw line through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE_LEVEL}};
                else        chain <= {chain[STAGES-2:0], rxd_i};
            end
            assign rx_sync = chain[STAGES-1];
        end
    endgenerate

    // Hold the previous synchronised level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_last <= IDLE_LEVEL;
        else        rx_last <= rx_sync;
    end

    assign change_o = rx_sync ^ rx_last;

endmodule

// File: rtl/csh_limit.sv
// Hold length lookup.
// Builds an eight-entry table, indexed by {mode, code}, from the package
// function. Each entry is a constant, so the table reduces to a small
// mux. Assumes CNT_W is wide enough for max_ticks(RATIO).
module csh_limit
    import csh_pkg::*;
#(
    parameter int unsigned RATIO = 16,
    parameter int          CNT_W = 7
) (
    input  logic [1:0]       code_i,
    input  logic             ovs_i,
    output logic [CNT_W-1:0] limit_o
);

    localparam int ENTRIES = 8;

    logic [CNT_W-1:0] table_q [ENTRIES];

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
            localparam int unsigned TICKS =
                hold_ticks(hold_code_e'(i % 4), (i >= 4) ? 1'b1 : 1'b0, RATIO);
            assign table_q[i] = CNT_W'(TICKS);
        end
    endgenerate

    // Select the entry for the current mode and code.
    always_comb begin
        limit_o = table_q[{ovs_i, code_i}];
    end

endmodule

// File: rtl/csh_hold_timer.sv
// Hold-off down counter.
// A detected change loads the full hold length and marks the line
// active. A strobe during an active hold removes one count, and the
// last count clears the active flag. A change takes priority over a
// strobe in the same cycle. Assumes limit_i is at least 1.
module csh_hold_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             change_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             active_o
);

    logic [CNT_W-1:0] remain_q;
    logic             active_q;

    // Reload on change, count down on strobes, expire at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            active_q <= 1'b0;
        end else if (change_i) begin
            remain_q <= limit_i;
            active_q <= 1'b1;
        end else if (tick_i && active_q) begin
            if (remain_q <= CNT_W'(1)) begin
                remain_q <= '0;
                active_q <= 1'b0;
            end else begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/csh_cs_out.sv
// Carrier-sense output stage.
// Registers the carrier-sense level as the active flag or the infinite
// hold override. It pulses the change output in the cycle the level
// moves. Resets to carrier present with no pulse.
module csh_cs_out (
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    input  logic active_i,
    output logic cs_o,
    output logic chg_o
);

    logic cs_next;
    logic cs_q;
    logic chg_q;

    assign cs_next = force_i | active_i;

    // Register the level and flag any difference from its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            chg_q <= 1'b0;
        end else begin
            cs_q  <= cs_next;
            chg_q <= cs_next ^ cs_q;
        end
    end

    assign cs_o  = cs_q;
    assign chg_o = chg_q;

endmodule

// File: rtl/cs_holdoff.sv
// Carrier sense hold-off timer, top level.
// Resynchronises the receive line, detects level changes, and times a
// programmable quiet period in tick_i strobes. It drives a registered
// carrier-sense level with a one-cycle change pulse. Assumes tick_i is
// a single-cycle strobe in the clk domain and OVS_RATIO is even.
module cs_holdoff
    import csh_pkg::*;
#(
    parameter int unsigned OVS_RATIO   = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic        IDLE_LEVEL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    input  logic       tick_i,
    input  logic       ovs_mode_i,
    input  logic [1:0] hold_code_i,
    output logic       cs_o,
    output logic       cs_chg_o
);

    localparam int unsigned MAX_HOLD = max_ticks(OVS_RATIO);
    localparam int          CNT_W    = $clog2(MAX_HOLD + 1);

    logic             edge_w;
    logic [CNT_W-1:0] limit_w;
    logic             active_w;
    logic             forever_w;

    assign forever_w = (hold_code_e'(hold_code_i) == HOLD_FOREVER);

    csh_rx_sync #(
        .STAGES     (SYNC_STAGES),
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_rx_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd_i    (rxd_i),
        .change_o (edge_w)
    );

    csh_limit #(
        .RATIO (OVS_RATIO),
        .CNT_W (CNT_W)
    ) u_limit (
        .code_i  (hold_code_i),
        .ovs_i   (ovs_mode_i),
        .limit_o (limit_w)
    );

    csh_hold_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .change_i (edge_w),
        .tick_i   (tick_i),
        .limit_i  (limit_w),
        .active_o (active_w)
    );

    csh_cs_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_i  (forever_w),
        .active_i (active_w),
        .cs_o     (cs_o),
        .chg_o    (cs_chg_o)
    );

endmodule

// File: rtl/csh_checker.sv
// Property checker for the carrier sense hold-off timer.
// Observes the top ports and the internal change and active nets. It is
// attached to every instance of the top through the bind below.
module csh_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic [1:0] code_i,
    input logic       edge_i,
    input logic       active_i,
    input logic       cs_i,
    input logic       chg_i
);

    // A detected change always leaves the timer active.
    assert_reload_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> active_i);

    // The hold can only start from a detected change.
    assert_start_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_i) |-> $past(edge_i));

    // Expiry happens only on a strobe that is not overridden by a change.
    assert_expire_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_i) |-> ($past(tick_i) && !$past(edge_i)));

    // Without strobes or changes the timer state does not move.
    assert_no_time_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && !tick_i) |=> $stable(active_i));

    // The infinite code keeps carrier sense up.
    assert_forever_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 2'b00) |=> cs_i);

    // Every level move is marked by the pulse.
    assert_pulse_on_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i != $past(cs_i)) |-> chg_i);

    // The pulse never appears without a level move.
    assert_pulse_only_on_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |-> (cs_i != $past(cs_i)));

endmodule

bind cs_holdoff csh_checker u_csh_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .code_i   (hold_code_i),
    .edge_i   (edge_w),
    .active_i (active_w),
    .cs_i     (cs_o),
    .chg_i    (cs_chg_o)
);

// File: tb/test_cs_holdoff.sv
// Self-checking bench: behavioural per-cycle model plus directed latency windows.
module test_cs_holdoff;

    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int SYNC       = 2;
    localparam int WATCHDOG   = 150000;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd   = 1'b1;
    logic       tick  = 1'b0;
    logic       ovs   = 1'b0;
    logic [1:0] code  = 2'b00;
    logic       cs;
    logic       chg;

    cs_holdoff #(
        .OVS_RATIO   (OVS),
        .SYNC_STAGES (SYNC)
    ) i_cs_holdoff (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd),
        .tick_i      (tick),
        .ovs_mode_i  (ovs),
        .hold_code_i (code),
        .cs_o        (cs),
        .cs_chg_o    (chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    tick_period = 1;
    int    tick_cnt = 0;
    string phase = "R1";

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe counts taken directly from the requirements.
    function automatic int exp_hold(int c, bit o);
        if (c == 1) return o ? (OVS * 13) / 2 : 14;
        if (c == 2) return o ? (OVS * 3) / 2 : 4;
        if (c == 3) return o ? OVS : 3;
        return 1;
    endfunction

    // Behavioural reference: line history queue and integer countdown.
    bit hist[$];
    bit m_act = 1'b0;
    int m_rem = 0;
    bit m_cs  = 1'b1;
    bit m_chg = 1'b0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < SYNC + 2; i++) hist.push_back(1'b1);
            m_act = 1'b0;
            m_rem = 0;
            m_cs  = 1'b1;
            m_chg = 1'b0;
        end else begin : model_step
            bit seen;
            bit nxt;
            hist.push_front(rxd);
            seen = (hist[SYNC] != hist[SYNC+1]);
            void'(hist.pop_back());
            nxt   = (code == 2'b00) || m_act;
            m_chg = (nxt != m_cs);
            m_cs  = nxt;
            if (seen) begin
                m_rem = exp_hold(int'(code), ovs);
                m_act = 1'b1;
            end else if (tick && m_act) begin
                m_rem--;
                if (m_rem == 0) m_act = 1'b0;
            end
        end
    end

    // Compare both outputs with the model on every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " cs_o model"}, int'(cs), int'(m_cs));
            check({phase, " cs_chg_o model"}, int'(chg), int'(m_chg));
        end
    end

    // Strobe generator: one strobe every tick_period cycles, none if 0.
    always @(negedge clk) begin
        tick_cnt++;
        tick = (tick_period != 0) && ((tick_cnt % ((tick_period != 0) ? tick_period : 1)) == 0);
    end

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        if (cycles == WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_reset(logic [1:0] c, logic o);
        @(negedge clk);
        rst_n = 1'b0;
        rxd   = 1'b1;
        code  = c;
        ovs   = o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Watch a window after a stimulus; record first rise, first fall, pulse count.
    task automatic watch(int n, output int rise, output int fall, output int pulses);
        rise = -1; fall = -1; pulses = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (chg) pulses++;
            if (cs && rise < 0) rise = k;
            else if (!cs && rise >= 0 && fall < 0) fall = k;
        end
    endtask

    task automatic single_hold(string tag, logic [1:0] c, logic o);
        int r, f, p, len;
        phase = tag;
        do_reset(c, o);
        tick_period = 1;
        len = exp_hold(int'(c), o);
        check({tag, " idle cs before change"}, int'(cs), 0);
        rxd = ~rxd;
        watch(len + SYNC + 10, r, f, p);
        check({tag, " R3 rise latency"}, r, SYNC + 2);
        check({tag, " fall latency"}, f, SYNC + 2 + len);
        check({tag, " R8 pulse count"}, p, 2);
    endtask

    int r, f, p;
    bit [15:0] lfsr;

    initial begin
        // R1: reset state with the infinite code.
        @(negedge clk);
        check("R1 cs in reset", int'(cs), 1);
        check("R1 chg in reset", int'(chg), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs after reset", int'(cs), 1);
        check("R1 chg after reset", int'(chg), 0);

        // R2: infinite hold under activity and long quiet.
        phase = "R2";
        for (int i = 0; i < 6; i++) begin
            rxd = ~rxd;
            repeat (7) @(negedge clk);
        end
        watch(200, r, f, p);
        check("R2 no pulses", p, 0);
        check("R2 cs still high", int'(cs), 1);

        // R4, R5, R6 in both modes; R11 holds since a strobe meets every change.
        single_hold("R4 1x", 2'b01, 1'b0);
        single_hold("R5 1x", 2'b10, 1'b0);
        single_hold("R6 1x", 2'b11, 1'b0);
        single_hold("R4 ovs", 2'b01, 1'b1);
        single_hold("R5 ovs", 2'b10, 1'b1);
        single_hold("R6 ovs", 2'b11, 1'b1);

        // R7: a second change two cycles later restarts the hold.
        phase = "R7";
        do_reset(2'b11, 1'b0);
        rxd = ~rxd;
        @(negedge clk);
        @(negedge clk);
        rxd = ~rxd;
        watch(30, r, f, p);
        check("R7 rise latency", r + 2, SYNC + 2);
        check("R7 fall after restart", f + 2, 2 + SYNC + 2 + 3);
        check("R7 pulse count", p, 2);

        // R9: shorten the code mid-hold; the loaded length stays.
        phase = "R9";
        do_reset(2'b01, 1'b0);
        rxd = ~rxd;
        repeat (6) @(negedge clk);
        code = 2'b11;
        watch(30, r, f, p);
        check("R9 fall keeps loaded length", f + 6, SYNC + 2 + 14);
        rxd = ~rxd;
        watch(30, r, f, p);
        check("R9 next hold uses new code", f, SYNC + 2 + 3);

        // R10: no strobes, no timeout; strobes then finish the hold.
        phase = "R10";
        do_reset(2'b11, 1'b0);
        tick_period = 0;
        rxd = ~rxd;
        watch(300, r, f, p);
        check("R10 cs held without strobes", int'(cs), 1);
        check("R10 no fall without strobes", f, -1);
        tick_period = 1;
        watch(10, r, f, p);
        check("R10 cs drops once strobes resume", int'(cs), 0);

        // Mixed random activity, model compared every cycle (R7, R11).
        phase = "R7 random 1x";
        do_reset(2'b11, 1'b0);
        tick_period = 2;
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) rxd = ~rxd;
        end
        phase = "R11 random ovs";
        do_reset(2'b11, 1'b1);
        tick_period = 1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[4:0] == 5'h0) rxd = ~rxd;
        end

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule